// File: doc/BRIEF.md
# Serial Flash Erase Command Decoder

This block is the device-side decoder for the erase commands of a serial flash with an SPI-style interface. While chip select is low it shifts in bits on rising clock edges, assembles bytes, and classifies the frame. It recognises two erase commands. The first is a one-byte sector erase opcode followed by three address bytes; the target sector comes from the page-address bits. The second is a chip erase, which needs an exact four-byte opcode sequence. A status-read opcode returns a status byte whose top bit shows whether the device is ready.

An accepted command does not start an erase when its last bit arrives. The erase starts only when chip select returns high. A cycle counter stands in for the self-timed erase. For the length of that count the block reports busy and holds the map of sectors being erased. Locked sectors are always spared. Protected sectors are spared while the write-protect pin is in effect. A change on that pin during an erase is held back until the erase finishes.

The sector space has nine slots. Slots 0 and 1 are the two sub-sectors 0a and 0b. Slot k+1 is sector k, for k from 1 to 7.

Top module: `serial_erase_ctrl`

## Requirements
- R1: A frame whose first byte is 7CH, followed by three address bytes, erases exactly one slot. Of the 24 address bits (first byte most significant), bits 17..15 give the sector number s. For s from 1 to 7 the erased slot is s+1, and bits 23..18 and 14..0 have no effect.
- R2: When bits 17..15 are zero, address bits 14..11 select the sub-sector: all zero selects slot 0 (0a), and any other value selects slot 1 (0b). Bits 23..18 and 10..0 have no effect.
- R3: The four-byte frame C7H, 94H, 80H, 9AH erases every slot that is not spared. Any bytes after the fourth are ignored.
- R4: No erase starts, and erase_done does not pulse, in any of these cases: a chip-erase sequence with any byte different, an unknown opcode, a sector erase with fewer than three address bytes, or a frame with no bytes.
- R5: A complete command starts nothing while chip select stays low. After chip select rises, busy goes high at the next clock edge.
- R6: busy stays high for exactly ERASE_CYCLES clock cycles, then erase_done pulses for one cycle. erase_map holds the erased slots from the start of the erase until the next erase starts.
- R7: The slots removed from an erase are lock_mask, together with prot_mask whenever wp_active is 1. This applies to both erase commands, and a fully spared erase still runs its full busy time.
- R8: wp_active follows wp_pin while the block is idle. While busy it keeps its value, and it takes up the pin's value after the erase ends.
- R9: A frame that arrives while busy starts no erase and does not lengthen the current one. A status read during an erase still answers.
- R10: After the opcode D7H, spi_miso presents the status byte MSB first. Bit 7 is 1 when ready and 0 when busy, and bits 6..0 are 0. The next bit appears after each rising spi_sck edge. spi_miso is 0 while chip select is high.
- R11: After reset, busy, erase_done, erase_map, wp_active and spi_miso are all 0.
- R12: spi_mosi is sampled on rising spi_sck edges while spi_cs_n is low, most significant bit first. The spi_* inputs are synchronous to clk, and each spi_sck level lasts at least two clk cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial status data out |
| wp_pin | input | 1 | Write-protect request |
| prot_mask | input | 9 | Slots protected while write-protect is in effect |
| lock_mask | input | 9 | Slots locked down permanently |
| busy | output | 1 | Erase in progress |
| erase_done | output | 1 | One-cycle pulse at the end of an erase |
| erase_map | output | 9 | Slots erased by the current or last erase |
| wp_active | output | 1 | Write-protect state currently in effect |

## Verification
Some rules are checked by the assertions on every cycle. Busy may only rise right after a chip-select rising edge. A new start never arrives while busy. wp_active is frozen during an erase. A freshly loaded erase map never includes a locked slot. A sector erase always targets a single slot. spi_miso is quiet while deselected, and bytes complete only on a serial clock edge. Other behaviour needs the bench's scenarios. These include the address-to-slot mapping over every sector and the sub-sector split. They also cover rejection of near-miss chip-erase sequences and truncated frames, and the exact busy length. The bench also checks the deferred write-protect update, and that a command issued mid-erase is dropped while a status read still answers.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  localparam int NSLOT   = 9;
  localparam int PAGE_W  = 7;
  localparam logic [7:0] OP_SECTOR = 8'h7C;
  localparam logic [7:0] OP_STATUS = 8'hD7;

  // Chip-erase opcode sequence, in the order it must arrive.
  function automatic logic [7:0] chip_seq_byte(input logic [1:0] idx);
    logic [7:0] b;
    case (idx)
      2'd0: b = 8'hC7;
      2'd1: b = 8'h94;
      2'd2: b = 8'h80;
      default: b = 8'h9A;
    endcase
    return b;
  endfunction

  // page = address bits 17..11. Sector number in 17..15, sub-sector in 14..11.
  function automatic logic [NSLOT-1:0] slot_of_page(input logic [PAGE_W-1:0] page);
    logic [NSLOT-1:0] t;
    logic [2:0] sec;
    t   = '0;
    sec = page[6:4];
    if (sec == 3'd0) begin
      if (page[3:0] == 4'd0) t[0] = 1'b1;
      else                   t[1] = 1'b1;
    end else begin
      t[4'(sec) + 4'd1] = 1'b1;
    end
    return t;
  endfunction

  function automatic logic [NSLOT-1:0] spared_slots(input logic [NSLOT-1:0] lock,
                                                    input logic [NSLOT-1:0] prot,
                                                    input logic wp);
    return lock | (wp ? prot : '0);
  endfunction
endpackage

// File: rtl/fer_spi_rx.sv
module fer_spi_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       mosi,
  output logic       sck_rise,
  output logic       byte_vld,
  output logic [7:0] byte_data,
  output logic [2:0] byte_num
);
  logic       sck_q;
  logic [6:0] shreg;
  logic [2:0] bitc;
  logic [2:0] bytec;

  assign sck_rise = sck && !sck_q && !cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q     <= 1'b0;
      shreg     <= '0;
      bitc      <= '0;
      bytec     <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
      byte_num  <= '0;
    end else begin
      sck_q    <= sck;
      byte_vld <= 1'b0;
      if (cs_n) begin
        bitc  <= '0;
        bytec <= '0;
      end else if (sck_rise) begin
        shreg <= {shreg[5:0], mosi};
        bitc  <= bitc + 3'd1;
        if (bitc == 3'd7) begin
          byte_vld  <= 1'b1;
          byte_data <= {shreg, mosi};
          byte_num  <= bytec;
          if (bytec != 3'd7) bytec <= bytec + 3'd1;
        end
      end
    end
  end

  // R12: a byte completes only on a sampled serial clock edge
  a_r12_byte_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> $past(sck_rise));
endmodule

// File: rtl/fer_cmd_decode.sv
module fer_cmd_decode
  import flash_erase_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             cs_rise,
  input  logic             byte_vld,
  input  logic [7:0]       byte_data,
  input  logic [2:0]       byte_num,
  input  logic             busy,
  output logic             start,
  output logic             start_chip,
  output logic [NSLOT-1:0] start_map,
  output logic             stat_sel
);
  logic [7:0]        op;
  logic              seq_ok;
  logic [PAGE_W-1:0] page;
  logic [2:0]        nrx;
  logic              ign;
  logic              sect_full;
  logic              chip_full;

  assign sect_full  = (op == OP_SECTOR) && (nrx >= 3'd4);
  assign chip_full  = seq_ok && (nrx >= 3'd4);
  assign start_chip = chip_full;
  assign start_map  = chip_full ? '1 : slot_of_page(page);
  assign start      = cs_rise && !ign && !busy && (sect_full || chip_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op       <= '0;
      seq_ok   <= 1'b0;
      page     <= '0;
      nrx      <= '0;
      ign      <= 1'b0;
      stat_sel <= 1'b0;
    end else if (cs_n) begin
      op       <= '0;
      seq_ok   <= 1'b0;
      page     <= '0;
      nrx      <= '0;
      ign      <= 1'b0;
      stat_sel <= 1'b0;
    end else if (byte_vld) begin
      nrx <= (byte_num == 3'd7) ? 3'd7 : byte_num + 3'd1;
      if (busy) ign <= 1'b1;
      case (byte_num)
        3'd0: begin
          op       <= byte_data;
          seq_ok   <= (byte_data == chip_seq_byte(2'd0));
          stat_sel <= (byte_data == OP_STATUS);
        end
        3'd1, 3'd2, 3'd3: begin
          if (byte_data != chip_seq_byte(byte_num[1:0])) seq_ok <= 1'b0;
          if (byte_num == 3'd1) page <= {byte_data[1:0], page[4:0]};
          if (byte_num == 3'd2) page <= {page[6:5], byte_data[7:3]};
        end
        default: ;
      endcase
    end
  end

  // R1: a sector erase always names a single slot
  a_r1_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !start_chip) |-> ($countones(start_map) == 1));
endmodule

// File: rtl/fer_erase_engine.sv
module fer_erase_engine
  import flash_erase_pkg::*;
#(
  parameter int ERASE_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NSLOT-1:0] start_map,
  input  logic [NSLOT-1:0] lock_mask,
  input  logic [NSLOT-1:0] prot_mask,
  input  logic             wp_pin,
  output logic             busy,
  output logic             erase_done,
  output logic [NSLOT-1:0] erase_map,
  output logic             wp_active
);
  localparam int CNT_W = $clog2(ERASE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ERASE_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      erase_done <= 1'b0;
      erase_map  <= '0;
      wp_active  <= 1'b0;
      cnt        <= '0;
    end else begin
      erase_done <= 1'b0;
      if (!busy) wp_active <= wp_pin;
      if (start) begin
        busy      <= 1'b1;
        cnt       <= CNT_LOAD;
        erase_map <= start_map & ~spared_slots(lock_mask, prot_mask, wp_active);
      end else if (busy) begin
        if (cnt == '0) begin
          busy       <= 1'b0;
          erase_done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R7: a freshly loaded map never touches a locked slot
  a_r7_locked_spared: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ((erase_map & $past(lock_mask)) == '0));
  // R8: write-protect state frozen during an erase
  a_r8_wp_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(wp_active));
  // R9: no new start arrives while busy
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
  // R6: the done pulse comes with busy already cleared
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    erase_done |-> (!busy && $past(busy)));
endmodule

// File: rtl/serial_erase_ctrl.sv
module serial_erase_ctrl
  import flash_erase_pkg::*;
#(
  parameter int ERASE_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_cs_n,
  input  logic             spi_sck,
  input  logic             spi_mosi,
  output logic             spi_miso,
  input  logic             wp_pin,
  input  logic [NSLOT-1:0] prot_mask,
  input  logic [NSLOT-1:0] lock_mask,
  output logic             busy,
  output logic             erase_done,
  output logic [NSLOT-1:0] erase_map,
  output logic             wp_active
);
  logic             cs_q;
  logic             cs_rise;
  logic             sck_rise;
  logic             byte_vld;
  logic [7:0]       byte_data;
  logic [2:0]       byte_num;
  logic             start;
  logic             start_chip;
  logic [NSLOT-1:0] start_map;
  logic             stat_sel;
  logic [2:0]       stat_ptr;
  logic [7:0]       status_byte;

  assign cs_rise     = spi_cs_n && !cs_q;
  assign status_byte = {!busy, 7'b0};

  fer_spi_rx u_rx (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi),
    .sck_rise(sck_rise), .byte_vld(byte_vld), .byte_data(byte_data), .byte_num(byte_num)
  );

  fer_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .cs_rise(cs_rise),
    .byte_vld(byte_vld), .byte_data(byte_data), .byte_num(byte_num), .busy(busy),
    .start(start), .start_chip(start_chip), .start_map(start_map), .stat_sel(stat_sel)
  );

  fer_erase_engine #(.ERASE_CYCLES(ERASE_CYCLES)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .start_map(start_map),
    .lock_mask(lock_mask), .prot_mask(prot_mask), .wp_pin(wp_pin),
    .busy(busy), .erase_done(erase_done), .erase_map(erase_map), .wp_active(wp_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= 1'b1;
      stat_ptr <= 3'd7;
      spi_miso <= 1'b0;
    end else begin
      cs_q <= spi_cs_n;
      if (spi_cs_n) begin
        stat_ptr <= 3'd7;
        spi_miso <= 1'b0;
      end else begin
        if (stat_sel && sck_rise) stat_ptr <= stat_ptr - 3'd1;
        spi_miso <= stat_sel && status_byte[stat_ptr];
      end
    end
  end

  // R5: an erase begins only right after chip select rises
  a_r5_start_on_csrise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise));
  // R10: data line quiet while deselected
  a_r10_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n)) |-> !spi_miso);
endmodule

// File: tb/sim_serial_erase_ctrl.sv
`timescale 1ns/1ps
module sim_serial_erase_ctrl;
  localparam int E = 300;
  localparam int N = 9;
  localparam logic [N-1:0] ALL = '1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp = 1'b0;
  logic [N-1:0] prot = '0, lock = '0;
  logic miso, busy, done, wpa;
  logic [N-1:0] emap;
  int checks = 0, fails = 0, done_cnt = 0;

  always #2 clk = ~clk;

  serial_erase_ctrl #(.ERASE_CYCLES(E)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .wp_pin(wp), .prot_mask(prot), .lock_mask(lock),
    .busy(busy), .erase_done(done), .erase_map(emap), .wp_active(wpa)
  );

  always @(negedge clk) if (done) done_cnt++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      mosi = b[i]; tick(2); sck = 1'b1; tick(2); sck = 1'b0;
    end
  endtask

  task automatic open_frame;  cs_n = 1'b0; tick(2); endtask
  task automatic close_frame; tick(3); cs_n = 1'b1; endtask

  task automatic sector_bytes(input logic [23:0] a);
    send_byte(8'h7C); send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
  endtask

  task automatic chip_bytes;
    send_byte(8'hC7); send_byte(8'h94); send_byte(8'h80); send_byte(8'h9A);
  endtask

  task automatic wait_erase(input logic [N-1:0] exp, input string req);
    int c = 0;
    for (int i = 0; i < E + 40; i++) begin
      tick(1);
      if (busy) c++;
      else if (c > 0) break;
    end
    chk(c == E, "R6", c, E);
    chk(emap == exp, req, int'(emap), int'(exp));
  endtask

  task automatic expect_none(input string req);
    int d0 = done_cnt;
    tick(E + 20);
    chk(done_cnt == d0 && !busy, req, done_cnt - d0, 0);
  endtask

  task automatic status_read(output logic b7, output logic b6);
    open_frame; send_byte(8'hD7); tick(4);
    b7 = miso;
    sck = 1'b1; tick(2); sck = 1'b0; tick(4);
    b6 = miso;
    close_frame; tick(3);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic s7, s6;
    logic [N-1:0] exp;
    int d0;
    tick(5);
    // R11 reset state
    chk(!busy && !done && emap == '0 && !wpa && !miso, "R11", {busy, done, wpa, miso}, 0);
    rst_n = 1'b1; tick(3);

    status_read(s7, s6);
    chk(s7 == 1'b1, "R10 ready bit", s7, 1);
    chk(s6 == 1'b0, "R10 bit6", s6, 0);

    // R1/R2/R12 sweep of sector and sub-sector decoding
    for (int hi = 0; hi < 8; hi++) begin
      for (int k = 0; k < 3; k++) begin
        logic [3:0] lo;
        logic [23:0] a;
        lo = (k == 0) ? 4'd0 : (k == 1) ? 4'd1 : 4'd9;
        a  = {6'(hi * 5 + k), 3'(hi), lo, 11'(hi * 97 + k * 13)};
        exp = '0;
        if (hi == 0) exp[(lo == 0) ? 0 : 1] = 1'b1;
        else exp[hi + 1] = 1'b1;
        open_frame; sector_bytes(a); close_frame;
        wait_erase(exp, (hi == 0) ? "R2 sub-sector" : "R1 sector");
      end
    end

    // R3 chip erase, plain and with trailing bytes
    open_frame; chip_bytes; close_frame;
    wait_erase(ALL, "R3 chip");
    open_frame; chip_bytes; send_byte(8'hFF); send_byte(8'h00); send_byte(8'hC7); close_frame;
    wait_erase(ALL, "R3 trailing");

    // R7 protection and lock
    lock = 9'h005; prot = 9'h0A0; wp = 1'b1; tick(3);
    chk(wpa == 1'b1, "R8 idle follow", wpa, 1);
    open_frame; chip_bytes; close_frame;
    wait_erase(ALL & ~9'h0A5, "R7 lock+prot");
    wp = 1'b0; tick(3);
    open_frame; chip_bytes; close_frame;
    wait_erase(ALL & ~9'h005, "R7 lock only");
    lock = 9'h010;
    open_frame; sector_bytes({6'h0, 3'd3, 15'h1234}); close_frame;
    wait_erase('0, "R7 locked sector");
    lock = '0; prot = '0;

    // R4 rejected frames
    open_frame; send_byte(8'hC7); send_byte(8'h94); send_byte(8'h81); send_byte(8'h9A); close_frame;
    expect_none("R4 byte3 mismatch");
    open_frame; send_byte(8'hC7); send_byte(8'h95); send_byte(8'h80); send_byte(8'h9A); close_frame;
    expect_none("R4 byte2 mismatch");
    open_frame; send_byte(8'hC7); send_byte(8'h94); send_byte(8'h80); close_frame;
    expect_none("R4 short chip");
    open_frame; send_byte(8'h7C); send_byte(8'h00); send_byte(8'h40); close_frame;
    expect_none("R4 short sector");
    open_frame; send_byte(8'h55); send_byte(8'h00); send_byte(8'h40); send_byte(8'h00); close_frame;
    expect_none("R4 unknown opcode");
    open_frame; close_frame;
    expect_none("R4 empty frame");

    // R5 nothing starts while chip select stays low
    open_frame; sector_bytes({6'h0, 3'd6, 15'h0}); tick(20);
    chk(!busy, "R5 held low", busy, 0);
    close_frame;
    exp = '0; exp[7] = 1'b1;
    wait_erase(exp, "R5 after rise");

    // R8 write-protect deferred
    prot = 9'h0F0; wp = 1'b0; tick(3);
    open_frame; chip_bytes; close_frame;
    tick(5); wp = 1'b1; tick(5);
    chk(busy && wpa == 1'b0, "R8 held during erase", wpa, 0);
    while (busy) tick(1);
    chk(emap == ALL, "R8 map", int'(emap), int'(ALL));
    tick(3);
    chk(wpa == 1'b1, "R8 applied after", wpa, 1);
    wp = 1'b0; prot = '0; tick(3);

    // R9 commands while busy ignored, status still answers
    d0 = done_cnt;
    open_frame; sector_bytes({6'h0, 3'd3, 15'h0}); close_frame;
    tick(5);
    chk(busy, "R9 busy", busy, 1);
    status_read(s7, s6);
    chk(s7 == 1'b0, "R10 busy bit", s7, 0);
    open_frame; sector_bytes({6'h0, 3'd5, 15'h0}); close_frame;
    while (busy) tick(1);
    exp = '0; exp[4] = 1'b1;
    chk(emap == exp, "R9 map kept", int'(emap), int'(exp));
    tick(E + 20);
    chk(done_cnt - d0 == 1 && !busy, "R9 single erase", done_cnt - d0, 1);
    chk(emap == exp, "R9 no second erase", int'(emap), int'(exp));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule